// File: doc/BRIEF.md
# Line-by-Line Colour Register Sequencer

This control block sits in a single-output colour imaging front end that carries up to three colours, one after another, on one analog channel. It takes the front end's mode bits and one asynchronous strobe pin. From them it produces four kinds of output:

- the effective mono and channel settings;
- the index of the colour whose gain and offset registers feed the channel;
- the reset-sampling and reset-clamp enables;
- the per-colour sample/hold and amplifier power enables.

The strobe pin has two roles, chosen by the mode bits:

- **Manual and normal operation:** it gates reset sampling, or reset clamping when the CDS bit is clear. A register field picks the colour.
- **Auto-cycle:** each pulse on the pin steps the applied colour set red, green, blue and back to red. The clamp then follows a register bit instead of the pin.

The block has no data stream. Every port is a plain control or status level.

Top module: `lbl_color_seq`

## Requirements
- R1: With `lbl_en` low, `mono_eff`/`chan_eff` equal `mono_in`/`chan_in`, `color_idx` is 00, and `acyc_en` and `man_sel` have no effect on any output.
- R2: With `lbl_en` high, `mono_eff` is 1 and `chan_eff` is 00 regardless of `mono_in` and `chan_in`.
- R3: `pwr_dn` and `sh_en` both use bit 0 = red, bit 1 = green, bit 2 = blue. `sh_en[c]` is the inverse of `pwr_dn[c]`, except that green and blue are forced off (0) while `lbl_en` is high.
- R4: With `lbl_en` high and `acyc_en` low, `color_idx` follows `man_sel`: 00 red, 01 green, 10 blue (`color_idx` uses the same encoding).
- R5: In that manual mode, `man_sel` = 11 gives `color_idx` 00. It also sets the sticky `cfg_invalid` flag one clock later, and the flag stays set until reset.
- R6: Outside auto-cycle, the strobe is synchronized through two flops. `strb_sync` = the synchronized strobe. `cds_en` = `strb_sync` AND `cds_in`, and `clamp_en` = `strb_sync` AND NOT `cds_in`. Both become valid two rising edges after the pin changes.
- R7: With `lbl_en` and `acyc_en` both high, each strobe pulse advances `color_idx` exactly once, in the order 00, 01, 10, 00. The change appears on the third rising edge after the pin rises, however long the pulse is held.
- R8: During auto-cycle, `clamp_en` equals `clamp_ctrl` and `cds_en` is 0. `cfg_err` is high exactly while auto-cycle is active and `cds_in` is 1.
- R9: The auto-cycle position is red after reset. It is held at red while auto-cycle is inactive, so every entry into auto-cycle starts at red.
- R10: During and right after reset, `cfg_invalid` is 0, `color_idx` is 00, and `cds_en` and `clamp_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lbl_en | input | 1 | Line-by-line mode |
| acyc_en | input | 1 | Auto-cycle mode (used only in line-by-line) |
| man_sel | input | 2 | Manual colour select |
| mono_in | input | 1 | Mono register bit |
| chan_in | input | 2 | Channel register field |
| clamp_ctrl | input | 1 | Clamp control bit used during auto-cycle |
| cds_in | input | 1 | Reset-sampling (CDS) register bit |
| pwr_dn | input | 3 | Per-colour power-down, bit0 red |
| strobe_pin | input | 1 | Asynchronous reset-sample strobe |
| mono_eff | output | 1 | Effective mono |
| chan_eff | output | 2 | Effective channel |
| color_idx | output | 2 | Applied gain/offset set: 00 red, 01 green, 10 blue |
| cds_en | output | 1 | Reset sampling enable |
| clamp_en | output | 1 | Reset-level clamp enable |
| sh_en | output | 3 | Per-colour sample/hold and amplifier enable |
| cfg_invalid | output | 1 | Sticky reserved-select flag |
| cfg_err | output | 1 | CDS requested while auto-cycling |

## Verification
The bench holds a strobe pulse high for several clocks. A design that advanced on the level rather than the edge would skip colours. It steps past blue, which catches a wrap to an unused code 11. It leaves and re-enters auto-cycle at green, which would expose a design that resumed from its old position. It also drives `man_sel` = 11 and then a legal code, which a non-sticky flag would fail. It flips the CDS bit in both strobe modes, which catches a swapped or missing reset-sampling/clamp selection.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
  localparam int NUM_COLORS = 3;
  localparam int IDX_W      = 2;
  typedef enum logic [IDX_W-1:0] {
    COL_RED = 2'b00,
    COL_GRN = 2'b01,
    COL_BLU = 2'b10,
    COL_RSV = 2'b11
  } color_e;
endpackage

// File: rtl/lbl_strobe_sync.sv
module lbl_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/lbl_cycle_ctr.sv
module lbl_cycle_ctr
  import lbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] pos_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_COLORS - 1);
  logic [IDX_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_q <= '0;
    else if (!active_i) pos_q <= '0;
    else if (step_i)    pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/lbl_mode_map.sv
module lbl_mode_map
  import lbl_pkg::*;
(
  input  logic                  lbl_i,
  input  logic                  auto_i,
  input  logic [IDX_W-1:0]      man_sel_i,
  input  logic [IDX_W-1:0]      seq_pos_i,
  input  logic                  mono_i,
  input  logic [1:0]            chan_i,
  input  logic                  clamp_ctrl_i,
  input  logic                  cds_i,
  input  logic                  strb_i,
  input  logic [NUM_COLORS-1:0] pwr_dn_i,
  output logic                  mono_o,
  output logic [1:0]            chan_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  cds_en_o,
  output logic                  clamp_en_o,
  output logic [NUM_COLORS-1:0] sh_en_o,
  output logic                  rsv_sel_o
);
  always_comb begin
    mono_o    = lbl_i ? 1'b1 : mono_i;
    chan_o    = lbl_i ? 2'b00 : chan_i;
    rsv_sel_o = 1'b0;
    if (!lbl_i)      idx_o = COL_RED;
    else if (auto_i) idx_o = seq_pos_i;
    else if (man_sel_i == COL_RSV) begin
      idx_o     = COL_RED;
      rsv_sel_o = 1'b1;
    end else         idx_o = man_sel_i;
    if (auto_i) begin
      cds_en_o   = 1'b0;
      clamp_en_o = clamp_ctrl_i;
    end else begin
      cds_en_o   = strb_i & cds_i;
      clamp_en_o = strb_i & ~cds_i;
    end
  end

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_pwr
    if (c == 0) begin : g_keep
      assign sh_en_o[c] = ~pwr_dn_i[c];
    end else begin : g_lbl_off
      assign sh_en_o[c] = ~pwr_dn_i[c] & ~lbl_i;
    end
  end
endmodule

// File: rtl/lbl_color_seq.sv
module lbl_color_seq
  import lbl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lbl_en,
  input  logic       acyc_en,
  input  logic [1:0] man_sel,
  input  logic       mono_in,
  input  logic [1:0] chan_in,
  input  logic       clamp_ctrl,
  input  logic       cds_in,
  input  logic [2:0] pwr_dn,
  input  logic       strobe_pin,
  output logic       mono_eff,
  output logic [1:0] chan_eff,
  output logic [1:0] color_idx,
  output logic       cds_en,
  output logic       clamp_en,
  output logic [2:0] sh_en,
  output logic       cfg_invalid,
  output logic       cfg_err
);
  logic             auto_act;
  logic             strb_lvl, strb_rise, rsv_sel;
  logic [IDX_W-1:0] seq_pos;
  logic             invalid_q;

  assign auto_act = lbl_en & acyc_en;

  lbl_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(strobe_pin),
    .level_o(strb_lvl), .rise_o(strb_rise)
  );

  lbl_cycle_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .active_i(auto_act),
    .step_i(strb_rise), .pos_o(seq_pos)
  );

  lbl_mode_map u_map (
    .lbl_i(lbl_en), .auto_i(auto_act), .man_sel_i(man_sel),
    .seq_pos_i(seq_pos), .mono_i(mono_in), .chan_i(chan_in),
    .clamp_ctrl_i(clamp_ctrl), .cds_i(cds_in), .strb_i(strb_lvl),
    .pwr_dn_i(pwr_dn), .mono_o(mono_eff), .chan_o(chan_eff),
    .idx_o(color_idx), .cds_en_o(cds_en), .clamp_en_o(clamp_en),
    .sh_en_o(sh_en), .rsv_sel_o(rsv_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       invalid_q <= 1'b0;
    else if (rsv_sel) invalid_q <= 1'b1;
  end

  assign cfg_invalid = invalid_q;
  assign cfg_err     = auto_act & cds_in;
endmodule

// File: rtl/lbl_color_seq_chk.sv
module lbl_color_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lbl_en,
  input logic       acyc_en,
  input logic [1:0] man_sel,
  input logic       clamp_ctrl,
  input logic       cds_in,
  input logic       mono_eff,
  input logic [1:0] chan_eff,
  input logic [1:0] color_idx,
  input logic       cds_en,
  input logic       clamp_en,
  input logic [2:0] sh_en,
  input logic       cfg_invalid
);
  logic auto_m;
  assign auto_m = lbl_en & acyc_en;

  p_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_en |-> (mono_eff && chan_eff == 2'b00));
  p_idx_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lbl_en |-> color_idx == 2'b00);
  p_gb_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_en |-> (!sh_en[1] && !sh_en[2]));
  p_no_rsv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    color_idx != 2'b11);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid |=> cfg_invalid);
  p_rsv_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lbl_en && !acyc_en && man_sel == 2'b11) |=> cfg_invalid);
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && $past(auto_m) && color_idx != $past(color_idx)) |->
      color_idx == (($past(color_idx) == 2'b10) ? 2'b00 : $past(color_idx) + 2'b01));
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_m |-> (clamp_en == clamp_ctrl && !cds_en));
  p_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_m) |-> color_idx == 2'b00);
  p_one_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_m |-> !(cds_en && clamp_en));
endmodule

bind lbl_color_seq lbl_color_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lbl_en(lbl_en), .acyc_en(acyc_en),
  .man_sel(man_sel), .clamp_ctrl(clamp_ctrl), .cds_in(cds_in),
  .mono_eff(mono_eff), .chan_eff(chan_eff), .color_idx(color_idx),
  .cds_en(cds_en), .clamp_en(clamp_en), .sh_en(sh_en),
  .cfg_invalid(cfg_invalid)
);

// File: tb/lbl_color_seq_tb_top.sv
module lbl_color_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lbl_en = 0, acyc_en = 0, mono_in = 0, clamp_ctrl = 0, cds_in = 0;
  logic       strobe_pin = 0;
  logic [1:0] man_sel = 0, chan_in = 0;
  logic [2:0] pwr_dn = 0;
  logic       mono_eff, cds_en, clamp_en, cfg_invalid, cfg_err;
  logic [1:0] chan_eff, color_idx;
  logic [2:0] sh_en;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lbl_color_seq dut_i (
    .clk(clk), .rst_n(rst_n), .lbl_en(lbl_en), .acyc_en(acyc_en),
    .man_sel(man_sel), .mono_in(mono_in), .chan_in(chan_in),
    .clamp_ctrl(clamp_ctrl), .cds_in(cds_in), .pwr_dn(pwr_dn),
    .strobe_pin(strobe_pin), .mono_eff(mono_eff), .chan_eff(chan_eff),
    .color_idx(color_idx), .cds_en(cds_en), .clamp_en(clamp_en),
    .sh_en(sh_en), .cfg_invalid(cfg_invalid), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hold);
    strobe_pin = 1; tick(hold);
    strobe_pin = 0; tick(4);
  endtask

  task automatic t_reset;
    check("R10 idx in reset", color_idx, 0);
    check("R10 invalid in reset", cfg_invalid, 0);
    rst_n = 1; tick(1);
    check("R10 idx after reset", color_idx, 0);
    check("R10 cds/clamp after reset", {cds_en, clamp_en}, 0);
  endtask

  task automatic t_pass;
    lbl_en = 0; acyc_en = 1; man_sel = 2'b10; mono_in = 0; chan_in = 2'b11; tick(1);
    check("R1 mono pass", mono_eff, 0);
    check("R1 chan pass", chan_eff, 3);
    check("R1 idx ignores sel/acyc", color_idx, 0);
    check("R1 clamp not auto", clamp_en, 0);
    pwr_dn = 3'b010; tick(1);
    check("R3 sh_en normal", sh_en, 3'b101);
  endtask

  task automatic t_forced;
    lbl_en = 1; acyc_en = 0; man_sel = 0; mono_in = 0; chan_in = 2'b10; pwr_dn = 0; tick(1);
    check("R2 mono forced", mono_eff, 1);
    check("R2 chan forced", chan_eff, 0);
    check("R3 gb off in lbl", sh_en, 3'b001);
    pwr_dn = 3'b001; tick(1);
    check("R3 red pd in lbl", sh_en, 3'b000);
    pwr_dn = 0;
  endtask

  task automatic t_manual;
    man_sel = 2'b01; tick(1); check("R4 green", color_idx, 1);
    man_sel = 2'b10; tick(1); check("R4 blue", color_idx, 2);
    man_sel = 2'b00; tick(1); check("R4 red", color_idx, 0);
    check("R5 no flag yet", cfg_invalid, 0);
    man_sel = 2'b11; tick(1);
    check("R5 reserved idx", color_idx, 0);
    check("R5 flag set", cfg_invalid, 1);
    man_sel = 2'b01; tick(2);
    check("R5 flag sticky", cfg_invalid, 1);
  endtask

  task automatic t_strobe_manual;
    cds_in = 1; strobe_pin = 1; tick(1);
    check("R6 cds not yet", cds_en, 0);
    tick(1);
    check("R6 cds on", cds_en, 1);
    check("R6 clamp off", clamp_en, 0);
    cds_in = 0; tick(1);
    check("R6 clamp on", clamp_en, 1);
    strobe_pin = 0; tick(2);
    check("R6 clamp released", clamp_en, 0);
  endtask

  task automatic t_auto;
    acyc_en = 1; clamp_ctrl = 1; tick(1);
    check("R9 start red", color_idx, 0);
    check("R8 clamp follows bit", clamp_en, 1);
    check("R8 no err", cfg_err, 0);
    strobe_pin = 1; tick(2);
    check("R7 not before edge 3", color_idx, 0);
    tick(1);
    check("R7 green on edge 3", color_idx, 1);
    tick(5);
    check("R7 once per pulse", color_idx, 1);
    check("R8 cds off in auto", cds_en, 0);
    strobe_pin = 0; tick(4);
    pulse(3); check("R7 blue", color_idx, 2);
    pulse(1); check("R7 wrap red", color_idx, 0);
    pulse(2); check("R7 green again", color_idx, 1);
    clamp_ctrl = 0; cds_in = 1; tick(1);
    check("R8 clamp bit low", clamp_en, 0);
    check("R8 cfg_err", cfg_err, 1);
    cds_in = 0;
    acyc_en = 0; tick(2); acyc_en = 1; tick(1);
    check("R9 reentry red", color_idx, 0);
  endtask

  initial begin
    tick(2);
    t_reset;
    t_pass;
    t_forced;
    t_manual;
    t_strobe_manual;
    t_auto;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule